// File: doc/BRIEF.md
# Serial Link Bus Error Classifier

This block sits beside the controller of a J1850-style serial link and sorts every bus error it can see into one status code. It watches decoded symbol events, the bit position within the current byte, whether a transmit is in progress, the level being driven against the level being sensed, and the stream of received bytes. From these it keeps a running CRC over each incoming frame. It checks framing and end symbols against byte boundaries, and it handles BREAK symbols differently for a transmitter and a receiver. It also notices a bus that is stuck active or stuck passive.

When a transmit must be abandoned, the block issues a one-cycle abort strobe. It then blocks further transmits until the processor issues a fresh transmit command. A bus held active for too long also blocks transmits, and this block lifts again as soon as the bus falls passive. The status code keeps the most recent error until software clears it. An interrupt request follows the status code whenever the enable input is set.

Top module: `link_err_classifier`

## Requirements
- R1: After reset, statusCode is 0, txAbort is 0, irq is 0 and txInhibit is 0.
- R2: The CRC register is preset to 0xFF after reset and after every EOD, EOF or BREAK symbol. Each rxByteValid cycle folds rxByte into it, MSB first, with polynomial 0x1D. An EOD (symKind 2) at bitPos 0 with a register value other than 0xC4 sets statusCode to 1 (CRC error) at the next edge. The byte must arrive at least one cycle before the EOD.
- R3: An EOD (symKind 2) or EOF (symKind 3) at a nonzero bitPos, when no live transmit is in progress, sets statusCode to 3 (framing).
- R4: An invalid symbol (symKind 5) sets statusCode to 2 when txActive is low. When txActive is high it sets statusCode to 4 (loss of arbitration) and raises no txAbort.
- R5: During a live transmit (txActive high, not held off), either of two conditions is a transmission error: an EOD or EOF at a nonzero bitPos, or txLevel high while busLevel is low (stuck passive). A transmission error sets statusCode to 5 and pulses txAbort for exactly one cycle after the edge.
- R6: A BREAK (symKind 4) during a live transmit sets statusCode to 7 and pulses txAbort. A BREAK at any other time sets statusCode to 6.
- R7: When conditions coincide in one cycle, the code is chosen in this order, highest first: BREAK (7/6), transmission error (5), framing (3), invalid symbol (4/2), CRC (1).
- R8: Each new error overwrites statusCode. Without a new error the code holds until statusClr, which sets it to 0 at the next edge. If an error and statusClr arrive in the same cycle, the error wins.
- R9: irq is high exactly when intEnable is high and statusCode is nonzero.
- R10: After a txAbort, txInhibit stays high and no further txAbort or transmission error occurs until a txRequest cycle. txInhibit drops at the edge after that cycle, unless the bus is stuck active.
- R11: If busLevel is sampled high on MAX_ACTIVE_CYC (default 40) consecutive edges, txInhibit rises after the last of them. It falls at the first edge that samples busLevel low, with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| symValid | input | 1 | A decoded symbol is present this cycle |
| symKind | input | 3 | 0/1 data bit, 2 EOD, 3 EOF, 4 BREAK, 5 invalid |
| bitPos | input | 3 | Bit count within the current byte, 0 on a byte boundary |
| txActive | input | 1 | The controller is transmitting |
| txLevel | input | 1 | Level driven by this node, 1 = active |
| busLevel | input | 1 | Level sensed on the bus, 1 = active |
| rxByteValid | input | 1 | rxByte holds a completed received byte |
| rxByte | input | 8 | Received byte for the CRC |
| txRequest | input | 1 | Processor command to transmit |
| statusClr | input | 1 | Processor write that clears the status code |
| intEnable | input | 1 | Interrupt enable |
| txAbort | output | 1 | One-cycle strobe that stops the current transmit |
| statusCode | output | 3 | Latest error code |
| irq | output | 1 | Interrupt request |
| txInhibit | output | 1 | Transmit may not start |

## Verification
The hardest states to reach from the ports are coincidences: a BREAK or an invalid symbol landing in the same cycle as a stuck-passive drive mismatch, and an abort hold-off that must swallow a persisting mismatch without a second strobe. Directed sequences set up the drive mismatch first and then inject each symbol, checking the code and the abort strobe on the following edge. CRC frames of random length and content are built with a bench CRC function and its complemented check byte. Half of them get one flipped bit, so both the 0xC4 residue path and the mismatch path are exercised many times.

// File: rtl/lec_pkg.sv
package lec_pkg;
  typedef enum logic [2:0] {
    SYM_D0  = 3'd0,
    SYM_D1  = 3'd1,
    SYM_EOD = 3'd2,
    SYM_EOF = 3'd3,
    SYM_BRK = 3'd4,
    SYM_BAD = 3'd5
  } symKind_e;

  typedef enum logic [2:0] {
    ST_NONE  = 3'd0,
    ST_CRC   = 3'd1,
    ST_SYM   = 3'd2,
    ST_FRAME = 3'd3,
    ST_ARB   = 3'd4,
    ST_TXERR = 3'd5,
    ST_RXBRK = 3'd6,
    ST_TXBRK = 3'd7
  } stCode_e;

  typedef struct packed {
    logic crcPreset;
    logic crcFeed;
  } dpStrobe_t;
endpackage

// File: rtl/lec_datapath.sv
module lec_datapath #(
  parameter int          BYTE_W         = 8,
  parameter logic [7:0]  CRC_POLY       = 8'h1D,
  parameter logic [7:0]  CRC_INIT       = 8'hFF,
  parameter logic [7:0]  CRC_RESIDUE    = 8'hC4,
  parameter int          MAX_ACTIVE_CYC = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  lec_pkg::dpStrobe_t strobe,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               busLevel,
  output logic               crcOk,
  output logic               stuckActive
);
  localparam int RUN_W = $clog2(MAX_ACTIVE_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MAX_ACTIVE_CYC - 1);

  logic [7:0]       crcReg;
  logic [7:0]       crcNext;
  logic [RUN_W-1:0] activeRun;

  // Bitwise CRC step, MSB of the byte first.
  always_comb begin
    crcNext = crcReg;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (crcNext[7] ^ rxByte[i]) crcNext = {crcNext[6:0], 1'b0} ^ CRC_POLY;
      else                        crcNext = {crcNext[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 crcReg <= CRC_INIT;
    else if (strobe.crcPreset) crcReg <= CRC_INIT;
    else if (strobe.crcFeed)   crcReg <= crcNext;
  end

  assign crcOk = (crcReg == CRC_RESIDUE);

  // Run length of the active bus level, saturating at the limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeRun   <= '0;
      stuckActive <= 1'b0;
    end else if (!busLevel) begin
      activeRun   <= '0;
      stuckActive <= 1'b0;
    end else begin
      if (activeRun != RUN_LAST) activeRun <= activeRun + 1'b1;
      stuckActive <= (activeRun == RUN_LAST);
    end
  end
endmodule

// File: rtl/lec_control.sv
module lec_control #(
  parameter int BIT_POS_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 symValid,
  input  logic [2:0]           symKind,
  input  logic [BIT_POS_W-1:0] bitPos,
  input  logic                 txActive,
  input  logic                 txLevel,
  input  logic                 busLevel,
  input  logic                 rxByteValid,
  input  logic                 txRequest,
  input  logic                 statusClr,
  input  logic                 crcOk,
  output lec_pkg::dpStrobe_t   strobe,
  output logic                 txAbort,
  output logic                 abortHold,
  output logic [2:0]           statusCode
);
  import lec_pkg::*;

  logic onBoundary, txLive, isEnd, isBrk, isBad, isEod;
  logic stuckPassive, txBrk, rxBrk, txErr, frameErr, crcErr;
  logic anyErr, abortNow;
  logic [2:0] nextCode;

  always_comb begin
    onBoundary   = (bitPos == '0);
    txLive       = txActive && !abortHold;
    isEnd        = symValid && (symKind == SYM_EOD || symKind == SYM_EOF);
    isEod        = symValid && (symKind == SYM_EOD);
    isBrk        = symValid && (symKind == SYM_BRK);
    isBad        = symValid && (symKind == SYM_BAD);
    stuckPassive = txLive && txLevel && !busLevel;
    txBrk        = isBrk && txLive;
    rxBrk        = isBrk && !txLive;
    txErr        = txLive && ((isEnd && !onBoundary) || stuckPassive);
    frameErr     = !txLive && isEnd && !onBoundary;
    crcErr       = isEod && onBoundary && !crcOk;
    abortNow     = txBrk || txErr;

    anyErr   = 1'b1;
    if (txBrk)         nextCode = ST_TXBRK;
    else if (rxBrk)    nextCode = ST_RXBRK;
    else if (txErr)    nextCode = ST_TXERR;
    else if (frameErr) nextCode = ST_FRAME;
    else if (isBad)    nextCode = txActive ? ST_ARB : ST_SYM;
    else if (crcErr)   nextCode = ST_CRC;
    else begin
      nextCode = ST_NONE;
      anyErr   = 1'b0;
    end

    strobe.crcPreset = isEnd || isBrk;
    strobe.crcFeed   = rxByteValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusCode <= ST_NONE;
      txAbort    <= 1'b0;
      abortHold  <= 1'b0;
    end else begin
      if (anyErr)         statusCode <= nextCode;
      else if (statusClr) statusCode <= ST_NONE;
      txAbort <= abortNow;
      if (abortNow)       abortHold <= 1'b1;
      else if (txRequest) abortHold <= 1'b0;
    end
  end
endmodule

// File: rtl/link_err_classifier.sv
module link_err_classifier #(
  parameter int BIT_POS_W      = 3,
  parameter int MAX_ACTIVE_CYC = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 symValid,
  input  logic [2:0]           symKind,
  input  logic [BIT_POS_W-1:0] bitPos,
  input  logic                 txActive,
  input  logic                 txLevel,
  input  logic                 busLevel,
  input  logic                 rxByteValid,
  input  logic [7:0]           rxByte,
  input  logic                 txRequest,
  input  logic                 statusClr,
  input  logic                 intEnable,
  output logic                 txAbort,
  output logic [2:0]           statusCode,
  output logic                 irq,
  output logic                 txInhibit
);
  lec_pkg::dpStrobe_t strobe;
  logic crcOk, stuckActive, abortHold;

  lec_control #(.BIT_POS_W(BIT_POS_W)) u_ctl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symKind(symKind),
    .bitPos(bitPos), .txActive(txActive), .txLevel(txLevel),
    .busLevel(busLevel), .rxByteValid(rxByteValid), .txRequest(txRequest),
    .statusClr(statusClr), .crcOk(crcOk), .strobe(strobe),
    .txAbort(txAbort), .abortHold(abortHold), .statusCode(statusCode)
  );

  lec_datapath #(.MAX_ACTIVE_CYC(MAX_ACTIVE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .busLevel(busLevel), .crcOk(crcOk), .stuckActive(stuckActive)
  );

  assign irq       = intEnable && (statusCode != 3'd0);
  assign txInhibit = stuckActive || abortHold;
endmodule

// File: rtl/link_err_classifier_chk.sv
module link_err_classifier_chk (
  input logic       clk,
  input logic       rstN,
  input logic       symValid,
  input logic [2:0] symKind,
  input logic       txActive,
  input logic       txLevel,
  input logic       busLevel,
  input logic       statusClr,
  input logic       txAbort,
  input logic [2:0] statusCode,
  input logic       txInhibit,
  input logic       stuckActive
);
  // R5: abort strobe lasts one cycle
  a_r5_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |=> !txAbort);

  // R5/R6: an abort always comes with a transmit-side code
  a_r6_abort_code: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> (statusCode == 3'd5 || statusCode == 3'd7));

  // R10: an abort leaves the transmit blocked
  a_r10_hold_after_abort: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> txInhibit);

  // R4: an invalid symbol while transmitting never aborts on its own
  a_r4_arb_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symKind == 3'd5 && txActive && !(txLevel && !busLevel)) |=> !txAbort);

  // R8: without a clear the code never returns to zero
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode != 3'd0 && !statusClr) |=> statusCode != 3'd0);

  // R8: with no event and no clear the code holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!symValid && !statusClr && !(txActive && txLevel && !busLevel)) |=> $stable(statusCode));

  // R11: a passive bus ends the stuck-active condition
  a_r11_recover: assert property (@(posedge clk) disable iff (!rstN)
    !busLevel |=> !stuckActive);
endmodule

bind link_err_classifier link_err_classifier_chk u_chk (
  .clk(clk), .rstN(rstN), .symValid(symValid), .symKind(symKind),
  .txActive(txActive), .txLevel(txLevel), .busLevel(busLevel),
  .statusClr(statusClr), .txAbort(txAbort), .statusCode(statusCode),
  .txInhibit(txInhibit), .stuckActive(stuckActive)
);

// File: tb/link_err_classifier_bench.sv
module link_err_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_ACT    = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 0, txActive = 0, txLevel = 0, busLevel = 0;
  logic rxByteValid = 0, txRequest = 0, statusClr = 0, intEnable = 0;
  logic [2:0] symKind = 0;
  logic [2:0] bitPos = 0;
  logic [7:0] rxByte = 0;
  logic txAbort, irq, txInhibit;
  logic [2:0] statusCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_err_classifier #(.MAX_ACTIVE_CYC(MAX_ACT)) u_link_err_classifier (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symKind(symKind),
    .bitPos(bitPos), .txActive(txActive), .txLevel(txLevel),
    .busLevel(busLevel), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .txRequest(txRequest), .statusClr(statusClr), .intEnable(intEnable),
    .txAbort(txAbort), .statusCode(statusCode), .irq(irq),
    .txInhibit(txInhibit)
  );

  function automatic logic [7:0] crcStep(logic [7:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h1D;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: inputs already set at negedge, results read at next negedge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    symValid = 0; rxByteValid = 0; txRequest = 0; statusClr = 0;
  endtask

  task automatic sym(logic [2:0] k, logic [2:0] p);
    symValid = 1; symKind = k; bitPos = p;
    tick();
  endtask

  task automatic clearAll();
    statusClr = 1; txRequest = 1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] fr[0:7];
    logic [7:0] c;
    int len, bad, pos;
    process::self().srandom(32'd1850);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 code", statusCode, 0);
    chk("R1 abort", txAbort, 0);
    chk("R1 irq", irq, 0);
    chk("R1 inhibit", txInhibit, 0);

    // R2 random frames, half corrupted
    intEnable = 1;
    for (int f = 0; f < 40; f++) begin
      len = 1 + ($urandom % 6);
      c = 8'hFF;
      for (int i = 0; i < len; i++) begin
        fr[i] = 8'($urandom);
        c = crcStep(c, fr[i]);
      end
      fr[len] = ~c;
      bad = $urandom % 2;
      pos = $urandom % (len + 1);
      if (bad != 0) fr[pos] = fr[pos] ^ (8'h01 << ($urandom % 8));
      for (int i = 0; i <= len; i++) begin
        rxByteValid = 1; rxByte = fr[i];
        tick();
      end
      sym(3'd2, 3'd0);
      chk("R2 crc residue", statusCode, bad ? 1 : 0);
      chk("R9 irq follows code", irq, bad ? 1 : 0);
      clearAll();
    end

    // R3 framing in receive
    sym(3'd2, 3'd3);
    chk("R3 off-boundary EOD", statusCode, 3);
    clearAll();
    sym(3'd3, 3'd5);
    chk("R3 off-boundary EOF", statusCode, 3);
    sym(3'd3, 3'd0);
    chk("R3 boundary EOF no change", statusCode, 3);
    clearAll();

    // R4 invalid symbol rx and tx
    sym(3'd5, 3'd2);
    chk("R4 invalid rx", statusCode, 2);
    txActive = 1;
    sym(3'd5, 3'd2);
    chk("R4 invalid tx code", statusCode, 4);
    chk("R4 invalid tx no abort", txAbort, 0);
    chk("R4 invalid tx no inhibit", txInhibit, 0);
    txActive = 0;
    clearAll();

    // R5 transmit framing error, R10 hold-off
    txActive = 1;
    sym(3'd3, 3'd6);
    chk("R5 tx framing code", statusCode, 5);
    chk("R5 abort pulse", txAbort, 1);
    chk("R10 inhibit after abort", txInhibit, 1);
    tick();
    chk("R5 abort single cycle", txAbort, 0);
    sym(3'd2, 3'd1);
    chk("R10 no second abort", txAbort, 0);
    chk("R10 held framing reports as rx", statusCode, 3);
    txActive = 0;
    clearAll();
    chk("R10 request releases inhibit", txInhibit, 0);

    // R5 stuck passive
    txActive = 1; txLevel = 1; busLevel = 0;
    tick();
    chk("R5 stuck passive code", statusCode, 5);
    chk("R5 stuck passive abort", txAbort, 1);
    statusClr = 1;
    tick();
    tick();
    chk("R10 persisting mismatch no abort", txAbort, 0);
    chk("R10 persisting mismatch no code", statusCode, 0);
    txActive = 0; txLevel = 0;
    clearAll();

    // R6 BREAK tx and rx
    txActive = 1;
    sym(3'd4, 3'd0);
    chk("R6 tx break code", statusCode, 7);
    chk("R6 tx break abort", txAbort, 1);
    txActive = 0;
    clearAll();
    sym(3'd4, 3'd4);
    chk("R6 rx break code", statusCode, 6);
    chk("R6 rx break no abort", txAbort, 0);
    clearAll();

    // R7 coincidences with stuck passive
    txActive = 1; txLevel = 1; busLevel = 0;
    symValid = 1; symKind = 3'd4; bitPos = 0;
    tick();
    chk("R7 break over tx error", statusCode, 7);
    clearAll();
    symValid = 1; symKind = 3'd5; bitPos = 0;
    tick();
    chk("R7 tx error over invalid", statusCode, 5);
    txActive = 0; txLevel = 0;
    clearAll();
    // framing over CRC: garbage byte then off-boundary EOD
    rxByteValid = 1; rxByte = 8'h55;
    tick();
    sym(3'd2, 3'd2);
    chk("R7 framing over crc", statusCode, 3);

    // R8 overwrite, clear collision, clear
    sym(3'd5, 3'd0);
    chk("R8 overwrite", statusCode, 2);
    statusClr = 1; symValid = 1; symKind = 3'd3; bitPos = 3'd7;
    tick();
    chk("R8 error beats clear", statusCode, 3);
    tick();
    chk("R8 holds", statusCode, 3);
    // R9 enable gating
    intEnable = 0;
    #1;
    chk("R9 irq masked", irq, 0);
    intEnable = 1;
    #1;
    chk("R9 irq enabled", irq, 1);
    statusClr = 1;
    tick();
    chk("R8 clear", statusCode, 0);

    // R11 stuck active
    busLevel = 1;
    repeat (MAX_ACT - 1) tick();
    chk("R11 not yet stuck", txInhibit, 0);
    tick();
    chk("R11 stuck active inhibit", txInhibit, 1);
    repeat (5) tick();
    chk("R11 still stuck", txInhibit, 1);
    busLevel = 0;
    tick();
    chk("R11 recovers", txInhibit, 0);
    chk("R11 no error code", statusCode, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule